// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a kick line driven by a processor and lowers an active-low timeout flag when the line has not changed level for a set time. The nominal window is 1.6 s. It is set as a number of clock cycles, so a simulation can use a short window. Either a rising or a falling transition of the kick line restarts the window. An active manual-reset request also restarts it. Once the flag falls, it stays low until one of these clearing events arrives.

An external supply monitor provides a supply-good level. While supply-good is low, the flag is held low and the timer is held at zero. When supply-good returns, the flag rises in the same cycle, with no minimum low time. An enable input stands in for a kick pin that is left floating: with enable low the watchdog is idle and the flag stays high. The block does not reset the processor. A system gets that behaviour only by routing the flag back into the manual-reset request.

Top module: `wdt_supervisor`

## Requirements
- R1: After `rst_n` is released, with supply-good high, `wdt_n_o` is high (1).
- R2: With enable high, supply-good high, `mr_n_i` high and a constant kick level, `wdt_n_o` falls after exactly `TIMEOUT_CYC` clock edges counted from the last clearing edge.
- R3: A rising transition of `kick_i` restarts the window and raises a low flag.
- R4: A falling transition of `kick_i` restarts the window and raises a low flag.
- R5: `mr_n_i` low (active-low request) restarts the window and raises the flag on the next edge. The window stays at zero while the request is held.
- R6: Once low, `wdt_n_o` stays low for as long as no clearing event occurs, however many cycles pass.
- R7: While `supply_ok_i` is low, `wdt_n_o` is low in the same cycle, with no clock edge needed, and the timer does not advance.
- R8: When `supply_ok_i` returns high, `wdt_n_o` is high in that same cycle and the window restarts from zero.
- R9: With `kick_en_i` low, `wdt_n_o` stays high, the timer is held at zero, and kick transitions have no effect.
- R10: A kick transition passes through a two-flop synchronizer, so the flag rises on the third clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | Kick line from the processor (asynchronous) |
| kick_en_i | input | 1 | High: watchdog active. Low: models a floating kick pin |
| mr_n_i | input | 1 | Manual-reset request, active low, synchronous |
| supply_ok_i | input | 1 | Supply-good from an external monitor, high when good |
| wdt_n_o | output | 1 | Active-low timeout flag |

## Verification
The bench counts the exact number of edges to expiry after reset and after each clearing event. An off-by-one counter would shift that count. It checks that the flag stays latched across many idle cycles, which a design that re-arms on its own would fail. It also measures the three-edge latency from a kick change to the flag rising, which exposes a missing or extra synchronizer stage. Supply-good is toggled with no clock edge between change and sample, so a registered flag path would show up. Disabled periods, held manual requests and long random runs compare every cycle against a reference model in the bench, which catches a timer that keeps running while the supply is bad or while the watchdog is disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Action chosen for the timer in one cycle, in priority order
    typedef enum logic [2:0] {
        ACT_PARK,     // supply bad or disabled: hold at zero, flag released
        ACT_RESTART,  // kick transition or manual request
        ACT_HOLD,     // already expired: keep latched
        ACT_EXPIRE,   // final count reached
        ACT_COUNT     // advance
    } wdt_act_e;

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic toggle_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], kick_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign toggle_o = st_q.sh[STAGES-1] ^ st_q.prev;

    // R10: a reported transition means the synchronized level moved on the last edge
    assert_toggle_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> ($past(st_q.sh[STAGES-1]) != st_q.sh[STAGES-1]) || $rose(rst_n));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic enable_i,
    input  logic mr_n_i,
    input  logic supply_ok_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } tmr_t;

    tmr_t     st_d, st_q;
    wdt_act_e act;

    always_comb begin
        if (!supply_ok_i || !enable_i)  act = ACT_PARK;
        else if (toggle_i || !mr_n_i)   act = ACT_RESTART;
        else if (st_q.expired)          act = ACT_HOLD;
        else if (st_q.cnt == LAST)      act = ACT_EXPIRE;
        else                            act = ACT_COUNT;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_PARK, ACT_RESTART: begin
                st_d.cnt     = '0;
                st_d.expired = 1'b0;
            end
            ACT_HOLD:   st_d = st_q;
            ACT_EXPIRE: begin
                st_d.cnt     = '0;
                st_d.expired = 1'b1;
            end
            default:    st_d.cnt = st_q.cnt + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = st_q.expired;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok_i && enable_i && toggle_i) |=> (!expired_o && st_q.cnt == '0));

    assert_manual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok_i && enable_i && !mr_n_i) |=> (!expired_o && st_q.cnt == '0));

    assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && supply_ok_i && enable_i && mr_n_i && !toggle_i) |=> expired_o);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (st_q.cnt == '0 && !expired_o));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q.cnt == '0 && !expired_o));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned TIMEOUT_MS  = 1600,
    parameter int unsigned TIMEOUT_CYC = CLK_HZ / 1000 * TIMEOUT_MS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic kick_en_i,
    input  logic mr_n_i,
    input  logic supply_ok_i,
    output logic wdt_n_o
);
    logic toggle;
    logic expired;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_i   (kick_i),
        .toggle_o (toggle)
    );

    wdt_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .toggle_i    (toggle),
        .enable_i    (kick_en_i),
        .mr_n_i      (mr_n_i),
        .supply_ok_i (supply_ok_i),
        .expired_o   (expired)
    );

    // Supply-good acts on the flag without a register in between
    assign wdt_n_o = supply_ok_i & ~expired;

    assert_supply_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |-> !wdt_n_o);

    assert_supply_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok_i) |-> wdt_n_o);

    assert_disabled_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick_en_i && $past(!kick_en_i) && supply_ok_i) |-> wdt_n_o);

endmodule

// File: tb/sim_wdt_supervisor.sv
`timescale 1ns/1ps
module sim_wdt_supervisor;
    localparam int unsigned T = 40;

    logic clk = 1'b0;
    logic rst_n, kick, en, mr_n, sup;
    logic wdt_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    bit m_s1, m_s2, m_prev, m_exp;
    int m_cnt;

    always #2.5 clk = ~clk;

    wdt_supervisor #(.TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .kick_en_i(en),
        .mr_n_i(mr_n), .supply_ok_i(sup), .wdt_n_o(wdt_n)
    );

    function automatic bit exp_flag();
        return sup && !m_exp;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: wdt_n_o actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock edge, reference updated with the inputs applied at that edge
    task automatic step();
        bit tog;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_exp = 0; m_cnt = 0;
        end else begin
            tog = m_s2 ^ m_prev;
            if (!sup || !en)          begin m_cnt = 0; m_exp = 0; end
            else if (tog || !mr_n)    begin m_cnt = 0; m_exp = 0; end
            else if (m_exp)           begin end
            else if (m_cnt == T - 1)  begin m_cnt = 0; m_exp = 1; end
            else                      m_cnt++;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = kick;
        end
        @(negedge clk);
    endtask

    task automatic run_model(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step();
            #0.5 chk(req, wdt_n, exp_flag());
        end
    endtask

    function automatic int steps_until(input logic lvl);
        return 0;
    endfunction

    initial begin
        int n;
        rst_n = 0; kick = 0; en = 1; mr_n = 1; sup = 1;
        repeat (3) step();
        rst_n = 1;
        #0.5 chk("R1", wdt_n, 1'b1);

        // R2: exact cycles to expiry from reset
        n = 0;
        while (wdt_n && n < 3 * T) begin step(); n++; #0.5; end
        chk_int("R2 cycles to timeout", n, T);
        chk("R2", wdt_n, exp_flag());

        // R6: latched over many idle cycles
        run_model(3 * T, "R6");
        chk("R6 still low", wdt_n, 1'b0);

        // R3 + R10: rising kick raises flag on third edge
        kick = 1; n = 0;
        while (!wdt_n && n < 10) begin step(); n++; #0.5; end
        chk_int("R10 rising latency", n, 3);
        chk("R3", wdt_n, exp_flag());
        run_model(T + 5, "R3");
        chk("R3 expired again", wdt_n, 1'b0);

        // R4: falling kick
        kick = 0; n = 0;
        while (!wdt_n && n < 10) begin step(); n++; #0.5; end
        chk_int("R4 falling latency", n, 3);
        run_model(T - 2, "R4");
        chk("R4 window restarted", wdt_n, 1'b1);
        run_model(5, "R4");
        chk("R4 expired", wdt_n, 1'b0);

        // R5: manual request held for a long stretch
        mr_n = 0;
        step(); #0.5 chk("R5 flag raised", wdt_n, 1'b1);
        run_model(2 * T, "R5 held");
        chk("R5 held high", wdt_n, 1'b1);
        mr_n = 1;
        run_model(T + 2, "R5");
        chk("R5 expired after release", wdt_n, 1'b0);

        // R7: supply drop is immediate and freezes the timer
        kick = 1; run_model(3, "R3");
        run_model(T / 2, "R7");
        sup = 0; #0.5 chk("R7 immediate low", wdt_n, 1'b0);
        run_model(3 * T, "R7");
        // R8: return is immediate and counts from zero
        sup = 1; #0.5 chk("R8 immediate high", wdt_n, 1'b1);
        run_model(T - 1, "R8");
        chk("R8 window from zero", wdt_n, 1'b1);
        run_model(2, "R8");
        chk("R8 expired", wdt_n, 1'b0);

        // R9: disabled, kicks and time have no effect
        en = 0; run_model(1, "R9");
        chk("R9 high", wdt_n, 1'b1);
        for (int i = 0; i < 3 * T; i++) begin
            if (i % 7 == 0) kick = ~kick;
            step(); #0.5 chk("R9", wdt_n, exp_flag());
        end
        chk("R9 still high", wdt_n, 1'b1);
        en = 1;

        // random mix against the reference model
        void'($urandom(1234));
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 99) < 2)  kick = ~kick;
            if ($urandom_range(0, 199) == 0) en = ~en;
            mr_n = ($urandom_range(0, 299) != 0);
            if ($urandom_range(0, 149) == 0) sup = ~sup;
            if (!en && $urandom_range(0, 3) == 0) en = 1;
            if (!sup && $urandom_range(0, 7) == 0) sup = 1;
            #0.5 chk("R2 R3 R4 R5 R6 R7 R8 R9 random", wdt_n, exp_flag());
            step();
            #0.5 chk("R2 R3 R4 R5 R6 R7 R8 R9 random", wdt_n, exp_flag());
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100_000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule